// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

The block holds a 16-bit counter that advances by one on every cycle where the timer clock enable is high. It also holds a 16-bit compare register, and a 4-bit mode field selects what happens when the counter reaches the compare value. In three of the modes the match drives an output latch high, drives it low or inverts it, and the block claims the pin through an output enable. In a fourth mode the match only raises the compare flag. The fifth mode is the event trigger. On a match it emits a one-cycle trigger and, when the converter is enabled, a converter-start strobe. At the next timer tick it clears the counter to zero, so the compare register acts as a period register with a period of compare+1 ticks.

Software writes the compare value and the mode through two write strobes that share one data bus. The compare flag and the overflow flag stay set until their clear inputs are pulsed. The timer value is brought out for observation.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the timer, the compare value and the mode are zero, and out_pin, out_en, cmp_flag, ovf_flag, trig and conv_start are all low.
- R2: The timer advances by exactly one on each clock where tick is high and holds its value otherwise. A wrap from 16'hFFFF to 0 sets ovf_flag, which stays set until ovf_clr is pulsed.
- R3: A match event occurs in the cycle after a tick that leaves the timer equal to the compare value, provided the mode is one of 4'b0010, 4'b1000, 4'b1001, 4'b1010 or 4'b1011. The event sets cmp_flag at the next edge. cmp_flag_clr clears the flag, and a set in the same cycle takes priority over the clear.
- R4: On a match event, mode 4'b1000 drives out_pin high, 4'b1001 drives it low and 4'b0010 inverts it, each taking effect at the next edge. out_en is high in exactly these three modes.
- R5: In mode 4'b1010 a match event sets only cmp_flag. out_en is low and out_pin keeps its value.
- R6: In mode 4'b1011, trig is high during the match-event cycle itself, and conv_start is high in that same cycle only when adc_en is high. out_en is low.
- R7: In mode 4'b1011 the next tick after a match event loads 0 into the timer instead of incrementing it, and this does not set ovf_flag.
- R8: If the compare value is rewritten so the timer no longer equals it before that next tick, the timer increments instead of clearing.
- R9: Writing a mode of 4'b0000 forces out_pin low at the next edge. In any inactive mode, a match sets no flag and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| cmp_we | input | 1 | Write strobe for the compare value |
| mode_we | input | 1 | Write strobe for the mode (low 4 bits of wdata) |
| wdata | input | 16 | Write data |
| adc_en | input | 1 | Converter enable, gates conv_start |
| cmp_flag_clr | input | 1 | Clears cmp_flag |
| ovf_clr | input | 1 | Clears ovf_flag |
| tmr | output | 16 | Current timer value |
| out_pin | output | 1 | Compare output latch |
| out_en | output | 1 | Output enable for out_pin |
| cmp_flag | output | 1 | Compare interrupt flag |
| ovf_flag | output | 1 | Timer overflow flag |
| trig | output | 1 | Special event trigger, one cycle |
| conv_start | output | 1 | Converter start strobe |

## Verification
Each pin mode is exercised by a match: set, clear, toggle twice with a new compare value between the two matches, and then flag-only. The flag-only case shows that the latch keeps its value while the pin is released. The trigger mode is run once with the converter enabled and once with it disabled, which separates trig from conv_start. Two trigger runs tell the committed timer reset apart from the reset cancelled by a compare rewrite. A full 65536-tick run checks that the genuine wrap sets the overflow flag while the trigger reset does not.

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cmp_we,
  input  logic         mode_we,
  input  logic [W-1:0] wdata,
  input  logic         adc_en,
  input  logic         cmp_flag_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] tmr,
  output logic         out_pin,
  output logic         out_en,
  output logic         cmp_flag,
  output logic         ovf_flag,
  output logic         trig,
  output logic         conv_start
);
  localparam logic [3:0] M_OFF = 4'b0000;
  localparam logic [3:0] M_TOG = 4'b0010;
  localparam logic [3:0] M_SET = 4'b1000;
  localparam logic [3:0] M_CLR = 4'b1001;
  localparam logic [3:0] M_IRQ = 4'b1010;
  localparam logic [3:0] M_TRG = 4'b1011;

  logic [W-1:0] tmr_q, cmp_q;
  logic [3:0]   mode_q;
  logic         tick_q, pend_q, latch_q, cflag_q, oflag_q;

  wire pin_mode = (mode_q == M_SET) | (mode_q == M_CLR) | (mode_q == M_TOG);
  wire active   = pin_mode | (mode_q == M_IRQ) | (mode_q == M_TRG);
  wire is_trg   = (mode_q == M_TRG);
  wire hit      = (tmr_q == cmp_q);
  wire evt      = tick_q & hit & active;
  wire clr_tmr  = tick & is_trg & hit & (pend_q | evt);
  wire wrap     = tick & ~clr_tmr & (tmr_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      cmp_q   <= '0;
      mode_q  <= M_OFF;
      tick_q  <= 1'b0;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
      cflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      tick_q <= tick;
      if (tick) tmr_q <= clr_tmr ? '0 : tmr_q + 1'b1;
      if (cmp_we) cmp_q <= wdata;
      if (mode_we) mode_q <= wdata[3:0];

      if (tick) pend_q <= 1'b0;
      else if (evt & is_trg) pend_q <= 1'b1;

      if (mode_we && wdata[3:0] == M_OFF) latch_q <= 1'b0;
      else if (evt) begin
        case (mode_q)
          M_SET:   latch_q <= 1'b1;
          M_CLR:   latch_q <= 1'b0;
          M_TOG:   latch_q <= ~latch_q;
          default: latch_q <= latch_q;
        endcase
      end

      if (evt) cflag_q <= 1'b1;
      else if (cmp_flag_clr) cflag_q <= 1'b0;

      if (wrap) oflag_q <= 1'b1;
      else if (ovf_clr) oflag_q <= 1'b0;
    end
  end

  assign tmr        = tmr_q;
  assign out_pin    = latch_q;
  assign out_en     = pin_mode;
  assign cmp_flag   = cflag_q;
  assign ovf_flag   = oflag_q;
  assign trig       = evt & is_trg;
  assign conv_start = evt & is_trg & adc_en;
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         mode_we,
  input logic [W-1:0] wdata,
  input logic         adc_en,
  input logic [W-1:0] tmr,
  input logic         out_pin,
  input logic         out_en,
  input logic         cmp_flag,
  input logic         ovf_flag,
  input logic         trig,
  input logic         conv_start
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tmr));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tmr) == {W{1'b1}});

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cmp_flag);

  p_no_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !out_en);

  p_conv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (trig && adc_en));

  p_trig_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && tick) |=> (tmr == '0 && !$rose(ovf_flag)));

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && wdata[3:0] == 4'b0000) |=> !out_pin);
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_we(mode_we), .wdata(wdata),
  .adc_en(adc_en), .tmr(tmr), .out_pin(out_pin), .out_en(out_en),
  .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .trig(trig), .conv_start(conv_start)
);

// File: tb/tmr_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmp_we = 1'b0, mode_we = 1'b0;
  logic adc_en = 1'b0, cmp_flag_clr = 1'b0, ovf_clr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] tmr;
  logic out_pin, out_en, cmp_flag, ovf_flag, trig, conv_start;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  tmr_cmp_unit dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wr_cmp(logic [15:0] v);
    cmp_we = 1'b1; wdata = v; @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic wr_mode(logic [3:0] m);
    mode_we = 1'b1; wdata = {12'd0, m}; @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic clr_flag();
    cmp_flag_clr = 1'b1; @(negedge clk); cmp_flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tmr", tmr, 0);
    chk("R1 outs", {out_pin, out_en, cmp_flag, ovf_flag, trig, conv_start}, 0);
  endtask

  task automatic t_pin_modes();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd2);
    chk("R4 out_en set", out_en, 1);
    ticks(2);
    chk("R2 count", tmr, 2);
    @(negedge clk);
    chk("R2 hold", tmr, 2);
    chk("R4 set", out_pin, 1);
    chk("R3 flag", cmp_flag, 1);
    clr_flag();
    chk("R3 clear", cmp_flag, 0);
    wr_mode(4'b1001); wr_cmp(16'd4);
    ticks(2); @(negedge clk);
    chk("R4 clr", out_pin, 0);
    wr_mode(4'b0010); wr_cmp(16'd5);
    ticks(1); @(negedge clk);
    chk("R4 tog1", out_pin, 1);
    wr_cmp(16'd7);
    ticks(2); @(negedge clk);
    chk("R4 tog2", out_pin, 0);
  endtask

  task automatic t_irq_only_and_off();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd1);
    ticks(1); @(negedge clk);
    clr_flag();
    wr_mode(4'b1010); wr_cmp(16'd3);
    chk("R5 out_en", out_en, 0);
    ticks(2); @(negedge clk);
    chk("R5 flag", cmp_flag, 1);
    chk("R5 latch kept", out_pin, 1);
    wr_mode(4'b0000);
    chk("R9 off low", out_pin, 0);
    clr_flag();
    wr_mode(4'b0101); wr_cmp(16'd4);
    ticks(1); @(negedge clk);
    chk("R9 inactive flag", cmp_flag, 0);
    chk("R9 inactive pin", {out_pin, trig}, 0);
  endtask

  task automatic t_trigger();
    do_reset();
    wr_mode(4'b1011); wr_cmp(16'd5); adc_en = 1'b1;
    ticks(5);
    chk("R6 trig", trig, 1);
    chk("R6 conv on", conv_start, 1);
    chk("R6 out_en", out_en, 0);
    @(negedge clk);
    chk("R6 pulse", {trig, conv_start}, 0);
    chk("R7 held", tmr, 5);
    ticks(1);
    chk("R7 clear", tmr, 0);
    chk("R7 no ovf", ovf_flag, 0);
    adc_en = 1'b0;
    ticks(5);
    chk("R6 trig2", trig, 1);
    chk("R6 conv off", conv_start, 0);
    wr_cmp(16'd9);
    ticks(1);
    chk("R8 cancel", tmr, 6);
  endtask

  task automatic t_overflow();
    do_reset();
    tick = 1'b1;
    for (int i = 0; i < 65535; i++) @(negedge clk);
    tick = 1'b0;
    chk("R2 top", tmr, 16'hFFFF);
    chk("R2 no ovf yet", ovf_flag, 0);
    ticks(1);
    chk("R2 wrap", tmr, 0);
    chk("R2 ovf", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R2 ovf clr", ovf_flag, 0);
  endtask

  initial begin
    t_reset();
    t_pin_modes();
    t_irq_only_and_off();
    t_trigger();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule